// File: doc/BRIEF.md
# Two-Port Semaphore Token Latches

This block holds a small bank of one-bit token latches that two agents, a left port and a right port, use to claim shared resources. Each latch is free, held by the left side or held by the right side. A port asks for a token by writing a zero to the latch and gives it back by writing a one. Reading a latch tells the port whether it holds the token: zero means "mine", one means "free or taken by the other side". The two ports therefore see complementary views of a held latch.

A latch also remembers a request from the side that does not hold it. When the holder lets go, the waiting side becomes the holder in the same clock edge, with no retry needed. If both ports ask for the same free latch in the same cycle, the left port gets it and the right request is kept as pending. A read is captured into a per-port output register and copied onto every data bit. That register changes only when its own port reads, so a write from the other port cannot alter a result already returned.

Accesses are single-cycle strobes with no back-pressure: every selected cycle is taken at the next rising clock edge. Reads appear on the data output one cycle after the read strobe and are held until the next read by that port.

Top module: `sem_bank`

## Requirements
- R1: After reset every latch is free, and both read outputs hold all ones until the first read.
- R2: A write with data bit 0 equal to 0 to a free latch gives that port the token. Afterwards the port reads all zeros and the other port reads all ones for that latch.
- R3: A read (select high, write low) loads the port's output register at the next rising edge with the port's view of the addressed latch, copied onto all DW bits. The register keeps its value in every cycle without a read by that port.
- R4: A zero written by the side that does not hold a latch leaves both ports' views of that latch unchanged.
- R5: A holder that writes a one with no request pending from the other side frees the latch, so both ports read all ones.
- R6: If the non-holding side wrote a zero while the other side held the latch, the holder's release hands the token to the waiting side at the same edge.
- R7: A one written by the non-holding side cancels its pending request, so a later release by the holder leaves the latch free.
- R8: Same-cycle requests from both ports on one free latch give the token to the left port. The right request stays pending.
- R9: Only the low log2(NSEM) address bits choose the latch, and only data bit 0 of a write is used. Other address bits and data bits have no effect.
- R10: Each latch acts alone: an access to one latch never changes another.
- R11: A read captures the latch state from before a write by the other port in the same cycle.
- R12: With select low, the write strobe and data have no effect on any latch or on the read output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left port semaphore select |
| l_addr | input | AW | Left port address; low bits pick the latch |
| l_we | input | 1 | Left port write strobe (low = read) |
| l_wdata | input | DW | Left port write data; bit 0 used |
| l_rdata | output | DW | Left port registered read data |
| r_sel | input | 1 | Right port semaphore select |
| r_addr | input | AW | Right port address; low bits pick the latch |
| r_we | input | 1 | Right port write strobe (low = read) |
| r_wdata | input | DW | Right port write data; bit 0 used |
| r_rdata | output | DW | Right port registered read data |

## Verification
A wrong owner or pending flag in a latch shows up on the first read of that latch by either port. It appears one cycle after the read strobe, as a word of the wrong polarity. A lost pending flag only shows after the holder's release, when the waiting side reads ones where it should read zeros. Because of this, the handover, cancel and tie scenarios each read both ports right after the release. A read register that loads without a read, or that loads after the write it should precede, shows up as a change of the held word or as the post-write value in the snapshot scenario.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NSEM = 8,
  parameter int AW   = 15,
  parameter int DW   = 9,
  localparam int SW  = $clog2(NSEM)
) (
  input  logic            sel,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  output logic [NSEM-1:0] req,
  output logic [NSEM-1:0] rel,
  output logic            rd,
  output logic [SW-1:0]   idx
);
  // upper address bits and upper data bits play no part in a semaphore access
  logic unused_bits;
  assign unused_bits = ^{addr[AW-1:SW], wdata[DW-1:1]};

  assign idx = addr[SW-1:0];
  assign rd  = sel && !we;

  always_comb begin
    req = '0;
    rel = '0;
    if (sel && we) begin
      if (wdata[0]) rel[idx] = 1'b1;
      else          req[idx] = 1'b1;
    end
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic own_l,
  output logic own_r
);
  owner_t owner_q, owner_d;
  logic   pend_l_q, pend_l_d;
  logic   pend_r_q, pend_r_d;

  always_comb begin
    owner_d  = owner_q;
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;
    if (l_rel) pend_l_d = 1'b0;
    if (r_rel) pend_r_d = 1'b0;
    unique case (owner_q)
      OWN_NONE: begin
        if (l_req) begin
          owner_d  = OWN_LEFT;
          pend_l_d = 1'b0;
          pend_r_d = r_req;
        end else if (r_req) begin
          owner_d  = OWN_RIGHT;
          pend_r_d = 1'b0;
        end
      end
      OWN_LEFT: begin
        if (r_req) pend_r_d = 1'b1;
        if (l_rel) begin
          if (pend_r_d) begin
            owner_d  = OWN_RIGHT;
            pend_r_d = 1'b0;
          end else begin
            owner_d = OWN_NONE;
          end
        end
      end
      OWN_RIGHT: begin
        if (l_req) pend_l_d = 1'b1;
        if (r_rel) begin
          if (pend_l_d) begin
            owner_d  = OWN_LEFT;
            pend_l_d = 1'b0;
          end else begin
            owner_d = OWN_NONE;
          end
        end
      end
      default: owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign own_l = (owner_q == OWN_LEFT);
  assign own_r = (owner_q == OWN_RIGHT);
endmodule

// File: rtl/sem_rd_reg.sv
module sem_rd_reg #(
  parameter int NSEM = 8,
  parameter int DW   = 9,
  localparam int SW  = $clog2(NSEM)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic [SW-1:0]   idx,
  input  logic [NSEM-1:0] view,
  output logic [DW-1:0]   rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '1;
    else if (rd) rdata <= {DW{view[idx]}};
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NSEM = 8,
  parameter int AW   = 15,
  parameter int DW   = 9,
  localparam int SW  = $clog2(NSEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic [AW-1:0] l_addr,
  input  logic          l_we,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_sel,
  input  logic [AW-1:0] r_addr,
  input  logic          r_we,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);
  logic [NSEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [NSEM-1:0] own_l, own_r;
  logic            l_rd, r_rd;
  logic [SW-1:0]   l_idx, r_idx;

  sem_port_dec #(.NSEM(NSEM), .AW(AW), .DW(DW)) u_dec_l (
    .sel(l_sel), .addr(l_addr), .we(l_we), .wdata(l_wdata),
    .req(l_req), .rel(l_rel), .rd(l_rd), .idx(l_idx)
  );

  sem_port_dec #(.NSEM(NSEM), .AW(AW), .DW(DW)) u_dec_r (
    .sel(r_sel), .addr(r_addr), .we(r_we), .wdata(r_wdata),
    .req(r_req), .rel(r_rel), .rd(r_rd), .idx(r_idx)
  );

  for (genvar g = 0; g < NSEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .l_req(l_req[g]), .l_rel(l_rel[g]),
      .r_req(r_req[g]), .r_rel(r_rel[g]),
      .own_l(own_l[g]), .own_r(own_r[g])
    );
  end

  // a port reads zero only for a latch it holds
  sem_rd_reg #(.NSEM(NSEM), .DW(DW)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .rd(l_rd), .idx(l_idx),
    .view(~own_l), .rdata(l_rdata)
  );

  sem_rd_reg #(.NSEM(NSEM), .DW(DW)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .rd(r_rd), .idx(r_idx),
    .view(~own_r), .rdata(r_rdata)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NSEM = 8,
  parameter int DW   = 9,
  localparam int SW  = $clog2(NSEM)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            l_sel,
  input logic            l_we,
  input logic            l_wbit,
  input logic [SW-1:0]   l_idx,
  input logic [DW-1:0]   l_rdata,
  input logic            r_sel,
  input logic            r_we,
  input logic            r_wbit,
  input logic [SW-1:0]   r_idx,
  input logic [DW-1:0]   r_rdata,
  input logic [NSEM-1:0] own_l,
  input logic [NSEM-1:0] own_r
);
  // R3
  rdata_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  // R3
  l_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_sel && !l_we) |=> $stable(l_rdata));

  // R3
  l_rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sel && !l_we) |=> (l_rdata[0] == !$past(own_l[l_idx])));

  // R3
  r_rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_sel && !r_we) |=> (r_rdata[0] == !$past(own_r[r_idx])));

  // R4
  l_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_sel && l_we && l_wbit) |=> ((own_l & $past(own_l)) == $past(own_l)));

  // R4
  r_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_sel && r_we && r_wbit) |=> ((own_r & $past(own_r)) == $past(own_r)));

  // R8
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sel && l_we && !l_wbit && r_sel && r_we && !r_wbit && (l_idx == r_idx)
      && !own_l[l_idx] && !own_r[l_idx]) |=> own_l[$past(l_idx)]);
endmodule

bind sem_bank sem_bank_chk #(.NSEM(NSEM), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel(l_sel), .l_we(l_we), .l_wbit(l_wdata[0]), .l_idx(l_addr[SW-1:0]),
  .l_rdata(l_rdata),
  .r_sel(r_sel), .r_we(r_we), .r_wbit(r_wdata[0]), .r_idx(r_addr[SW-1:0]),
  .r_rdata(r_rdata),
  .own_l(own_l), .own_r(own_r)
);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;
  localparam int NSEM = 8;
  localparam int AW   = 15;
  localparam int DW   = 9;
  localparam logic [DW-1:0] ONES  = '1;
  localparam logic [DW-1:0] ZEROS = '0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          l_sel = 0, l_we = 0, r_sel = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sem_bank #(.NSEM(NSEM), .AW(AW), .DW(DW)) u_sem_bank (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_addr(l_addr), .l_we(l_we), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_addr(r_addr), .r_we(r_we), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit right, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    if (right) begin r_sel = 1; r_we = 1; r_addr = a; r_wdata = d; end
    else       begin l_sel = 1; l_we = 1; l_addr = a; l_wdata = d; end
    @(negedge clk);
    l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
  endtask

  task automatic rd(input bit right, input logic [AW-1:0] a, output logic [DW-1:0] q);
    @(negedge clk);
    if (right) begin r_sel = 1; r_we = 0; r_addr = a; end
    else       begin l_sel = 1; l_we = 0; l_addr = a; end
    @(negedge clk);
    q = right ? r_rdata : l_rdata;
    l_sel = 0; r_sel = 0;
  endtask

  task automatic expect_both(input string tag, input logic [AW-1:0] a,
                             input logic [DW-1:0] el, input logic [DW-1:0] er);
    logic [DW-1:0] q;
    rd(0, a, q); chk({tag, " left"}, q, el);
    rd(1, a, q); chk({tag, " right"}, q, er);
  endtask

  task automatic t_reset;
    chk("R1 left rdata after reset", l_rdata, ONES);
    chk("R1 right rdata after reset", r_rdata, ONES);
    for (int i = 0; i < NSEM; i++) expect_both("R1 free after reset", AW'(i), ONES, ONES);
  endtask

  task automatic t_acquire_release;
    wr(0, 2, ZEROS);
    expect_both("R2 left acquires 2", 2, ZEROS, ONES);
    expect_both("R10 latch 3 untouched", 3, ONES, ONES);
    wr(0, 2, ONES);
    expect_both("R5 left frees 2", 2, ONES, ONES);
    wr(1, 3, ZEROS);
    expect_both("R2 right acquires 3", 3, ONES, ZEROS);
    wr(1, 3, ONES);
  endtask

  task automatic t_pending_handover;
    wr(0, 2, ZEROS);
    wr(1, 2, ZEROS);
    expect_both("R4 right zero ignored while left holds", 2, ZEROS, ONES);
    wr(0, 2, ONES);
    expect_both("R6 handover to right", 2, ONES, ZEROS);
    wr(1, 2, ONES);
    expect_both("R5 right frees 2", 2, ONES, ONES);
  endtask

  task automatic t_cancel;
    wr(0, 5, ZEROS);
    wr(1, 5, ZEROS);
    wr(1, 5, ONES);
    expect_both("R7 cancel keeps left holder", 5, ZEROS, ONES);
    wr(0, 5, ONES);
    expect_both("R7 release after cancel frees", 5, ONES, ONES);
  endtask

  task automatic t_tie;
    @(negedge clk);
    l_sel = 1; l_we = 1; l_addr = 6; l_wdata = ZEROS;
    r_sel = 1; r_we = 1; r_addr = 6; r_wdata = ZEROS;
    @(negedge clk);
    l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
    expect_both("R8 tie won by left", 6, ZEROS, ONES);
    wr(0, 6, ONES);
    expect_both("R8 loser was pending", 6, ONES, ZEROS);
    wr(1, 6, ONES);
  endtask

  task automatic t_addr_data;
    logic [DW-1:0] q;
    wr(0, 15'h7FF9, 9'h1FE);
    rd(0, 1, q); chk("R9 upper addr/data bits ignored on request", q, ZEROS);
    expect_both("R10 latch 0 untouched", 0, ONES, ONES);
    wr(0, 15'h2001, 9'h001);
    rd(1, 15'h5551, q); chk("R9 release via aliased addr", q, ONES);
    rd(0, 1, q); chk("R9 left freed", q, ONES);
  endtask

  task automatic t_select_off;
    logic [DW-1:0] q;
    @(negedge clk);
    l_sel = 0; l_we = 1; l_addr = 0; l_wdata = ZEROS;
    @(negedge clk);
    l_we = 0;
    expect_both("R12 unselected write ignored", 0, ONES, ONES);
    wr(0, 4, ZEROS);
    rd(0, 4, q); chk("R3 left reads held latch", q, ZEROS);
    @(negedge clk);
    l_sel = 0; l_we = 0; l_addr = 3;
    @(negedge clk);
    chk("R3 rdata held without read", l_rdata, ZEROS);
    chk("R12 unselected read leaves rdata", l_rdata, ZEROS);
  endtask

  task automatic t_snapshot;
    logic [DW-1:0] q;
    wr(1, 4, ZEROS);
    @(negedge clk);
    l_sel = 1; l_we = 1; l_addr = 4; l_wdata = ONES;
    r_sel = 1; r_we = 0; r_addr = 4;
    @(negedge clk);
    l_sel = 0; l_we = 0; r_sel = 0;
    chk("R11 read takes pre-write state", r_rdata, ONES);
    rd(1, 4, q); chk("R11 next read sees handover", q, ZEROS);
    wr(1, 4, ONES);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_acquire_release();
    t_pending_handover();
    t_cancel();
    t_tie();
    t_addr_data();
    t_select_off();
    t_snapshot();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule